// File: doc/BRIEF.md
# Correlating Global-History Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short register of recent resolved branch outcomes, the global history. It combines that history with the low bits of the branch address to choose one 2-bit saturating counter in a pattern table. The counter's upper bit is the guess. A parameter picks how history and address are combined. One way joins them side by side, with the history as the upper index bits. The other XORs them, so the address range can stay wide while the history still spreads branches across the table.

The fetch side presents an address on the lookup port and receives the direction and the history value used, both combinationally in the same cycle. When the branch later resolves, the execute side returns the address, the real outcome and that saved history value on the update port. The counter that the lookup consulted is then trained, even if newer branches have shifted the live history in the meantime. Each accepted update also shifts its outcome into the live history.

The update port is a valid/ready stream. `upd_ready` is held high at all times, because one update completes every cycle. A sender may therefore treat every cycle with `upd_valid` high as a transfer, and no update is ever held back. The lookup port is a plain combinational query and has no handshake. The history width must be at least 1.

Top module: `bp_corr_predictor`

## Requirements
- R1: After reset every counter holds 2'b01 (weakly not taken) and the history is all zeros, so every lookup returns not taken and `pred_hist` reads 0.
- R2: `pred_taken` is the upper bit of the counter picked by `pred_pc` and the live history, and it follows `pred_pc` in the same cycle with no clock edge in between.
- R3: Each counter saturates. A taken update adds one and stops at 2'b11. A not-taken update subtracts one and stops at 2'b00.
- R4: From a strong state, the predicted direction changes only after two consecutive updates against it. A single contrary update leaves the prediction unchanged.
- R5: On each accepted update the history shifts one place toward its upper end and the outcome enters bit 0, with 1 meaning taken. `pred_hist` shows the live history.
- R6: With `HASH_XOR`=0 the table index is {history, pc[PC_BITS-1:0]}, with the history in the upper bits. The same address under two different histories uses two separate counters.
- R7: With `HASH_XOR`=1 the table index is pc XOR history, both zero-extended to the wider of the two widths. Different (pc, history) pairs with the same XOR share one counter.
- R8: There is no address tag. An update changes only the single counter it selects, and every other counter keeps its value.
- R9: An update trains the counter selected by `upd_pc` and `upd_hist`, not by the live history at the time of the update.
- R10: `upd_ready` is always 1. While `upd_valid` is 0, no counter and no history bit changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_BITS | Low address bits of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_BITS | Live global history used by this lookup, to be returned at update |
| upd_valid | input | 1 | Update transfer present |
| upd_ready | output | 1 | Update accepted; always high |
| upd_pc | input | PC_BITS | Low address bits of the resolved branch |
| upd_hist | input | HIST_BITS | History value that was reported at lookup time |
| upd_taken | input | 1 | Real outcome, 1 = taken |

## Verification
The assertions assume that update inputs are known values whenever `upd_valid` is high. They also assume that `upd_hist` may be any value, not only one the block once reported, so no property ties it to the live history. The stimulus changes inputs only on the falling clock edge and drops `upd_valid` after one cycle. During idle stretches it deliberately puts junk on the address, history and outcome pins. Returned histories are sometimes stale, so the update index differs from the live index.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT = 2'b01;
  localparam ctr2_t CTR_MAX     = 2'b11;
  localparam ctr2_t CTR_MIN     = 2'b00;

  // saturating step toward the observed outcome
  function automatic ctr2_t ctr_step(input ctr2_t cur, input logic taken);
    ctr2_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else       nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return nxt;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bp_index_hash.sv
module bp_index_hash #(
  parameter int unsigned PC_BITS   = 10,
  parameter int unsigned HIST_BITS = 2,
  parameter bit          HASH_XOR  = 1'b0,
  parameter int unsigned IDX_W     = 12
) (
  input  logic [PC_BITS-1:0]   pc,
  input  logic [HIST_BITS-1:0] hist,
  output logic [IDX_W-1:0]     idx
);

  generate
    if (HASH_XOR) begin : g_xor
      always_comb idx = IDX_W'(pc) ^ IDX_W'(hist);
    end else begin : g_cat
      always_comb idx = {hist, pc};
    end
  endgenerate

endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int unsigned HIST_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic [HIST_BITS-1:0] hist
);

  generate
    if (HIST_BITS > 1) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist <= '0;
        else if (shift_en) hist <= {hist[HIST_BITS-2:0], bit_in};
      end

      p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist[0] == $past(bit_in)) &&
                     (hist[HIST_BITS-1:1] == $past(hist[HIST_BITS-2:0])));
    end else begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist <= '0;
        else if (shift_en) hist <= bit_in;
      end

      p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist[0] == $past(bit_in));
    end
  endgenerate

  p_hist_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));

endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int unsigned IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_step(mem[wr_idx], wr_taken);
    end
  end

  always_comb rd_ctr = mem[rd_idx];

  // taken training never leaves the entry at the not-taken floor
  p_taken_off_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken) |=> mem[$past(wr_idx)] != CTR_MIN);

  p_nt_off_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken) |=> mem[$past(wr_idx)] != CTR_MAX);

  // with no write, a steady lookup sees a steady counter
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($past(rd_idx) != rd_idx) || $stable(rd_ctr));

endmodule

// File: rtl/bp_corr_predictor.sv
module bp_corr_predictor
  import bp_pkg::*;
#(
  parameter int unsigned PC_BITS   = 10,
  parameter int unsigned HIST_BITS = 2,
  parameter bit          HASH_XOR  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_BITS-1:0]   pred_pc,
  output logic                 pred_taken,
  output logic [HIST_BITS-1:0] pred_hist,
  input  logic                 upd_valid,
  output logic                 upd_ready,
  input  logic [PC_BITS-1:0]   upd_pc,
  input  logic [HIST_BITS-1:0] upd_hist,
  input  logic                 upd_taken
);

  localparam int unsigned IDX_W = HASH_XOR ? max_u(PC_BITS, HIST_BITS)
                                           : PC_BITS + HIST_BITS;

  logic [HIST_BITS-1:0] live_hist;
  logic [IDX_W-1:0]     look_idx;
  logic [IDX_W-1:0]     train_idx;
  ctr2_t                look_ctr;
  logic                 upd_fire;

  assign upd_ready = 1'b1;
  assign upd_fire  = upd_valid && upd_ready;

  bp_ghist #(.HIST_BITS(HIST_BITS)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_fire),
    .bit_in   (upd_taken),
    .hist     (live_hist)
  );

  bp_index_hash #(
    .PC_BITS(PC_BITS), .HIST_BITS(HIST_BITS), .HASH_XOR(HASH_XOR), .IDX_W(IDX_W)
  ) u_look_hash (
    .pc   (pred_pc),
    .hist (live_hist),
    .idx  (look_idx)
  );

  bp_index_hash #(
    .PC_BITS(PC_BITS), .HIST_BITS(HIST_BITS), .HASH_XOR(HASH_XOR), .IDX_W(IDX_W)
  ) u_train_hash (
    .pc   (upd_pc),
    .hist (upd_hist),
    .idx  (train_idx)
  );

  bp_pht #(.IDX_W(IDX_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (look_idx),
    .rd_ctr   (look_ctr),
    .wr_en    (upd_fire),
    .wr_idx   (train_idx),
    .wr_taken (upd_taken)
  );

  assign pred_taken = look_ctr[1];
  assign pred_hist  = live_hist;

  p_idle_hist_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(pred_hist));

  p_newest_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> pred_hist[0] == $past(upd_taken));

endmodule

// File: tb/bp_corr_predictor_tb_top.sv
module bp_corr_predictor_tb_top;

  localparam int PCB = 10;
  localparam int HB  = 2;
  localparam int XPC = 6;
  localparam int XHB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [PCB-1:0] pred_pc = '0;
  logic           pred_taken;
  logic [HB-1:0]  pred_hist;
  logic           upd_valid = 1'b0;
  logic           upd_ready;
  logic [PCB-1:0] upd_pc = '0;
  logic [HB-1:0]  upd_hist = '0;
  logic           upd_taken = 1'b0;

  logic [XPC-1:0] x_pred_pc = '0;
  logic           x_pred_taken;
  logic [XHB-1:0] x_pred_hist;
  logic           x_upd_valid = 1'b0;
  logic           x_upd_ready;
  logic [XPC-1:0] x_upd_pc = '0;
  logic [XHB-1:0] x_upd_hist = '0;
  logic           x_upd_taken = 1'b0;

  bp_corr_predictor #(.PC_BITS(PCB), .HIST_BITS(HB), .HASH_XOR(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken));

  bp_corr_predictor #(.PC_BITS(XPC), .HIST_BITS(XHB), .HASH_XOR(1'b1)) dut_x (
    .clk(clk), .rst_n(rst_n), .pred_pc(x_pred_pc), .pred_taken(x_pred_taken),
    .pred_hist(x_pred_hist), .upd_valid(x_upd_valid), .upd_ready(x_upd_ready),
    .upd_pc(x_upd_pc), .upd_hist(x_upd_hist), .upd_taken(x_upd_taken));

  int nchk = 0;
  int nerr = 0;

  // reference counters for the concatenating instance, built from R1/R3/R6
  int unsigned mdl [0:(1<<(PCB+HB))-1];
  logic [HB-1:0] mhist;

  localparam logic [PCB-1:0] SCR_PC = 10'h3FF;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic resolve(input logic [PCB-1:0] pc, input logic [HB-1:0] h, input logic t);
    int unsigned i;
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_hist = h; upd_taken = t;
    @(negedge clk);
    upd_valid = 1'b0;
    i = {h, pc};
    if (t) mdl[i] = (mdl[i] == 3) ? 3 : mdl[i] + 1;
    else   mdl[i] = (mdl[i] == 0) ? 0 : mdl[i] - 1;
    mhist = {mhist[HB-2:0], t};
  endtask

  // steer the live history to h using the scratch entry {11, SCR_PC}
  task automatic set_hist(input logic [HB-1:0] h);
    for (int b = HB-1; b >= 0; b--) resolve(SCR_PC, 2'b11, h[b]);
  endtask

  task automatic look(input logic [PCB-1:0] pc, input string tag, input int exp);
    pred_pc = pc;
    #1;
    chk(tag, pred_taken, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 hist after reset", pred_hist, 0);
    look(10'h000, "R1 pc0", 0);
    look(10'h155, "R1 pc155", 0);
    look(10'h3FE, "R1 pc3FE", 0);
    x_pred_pc = 6'h2A; #1;
    chk("R1 xor inst", x_pred_taken, 0);
    chk("R10 ready", upd_ready, 1);
  endtask

  task automatic t_hysteresis;
    resolve(10'h005, 2'b00, 1'b1); set_hist(2'b00);
    look(10'h005, "R3 one taken step", 1);
    resolve(10'h005, 2'b00, 1'b1); resolve(10'h005, 2'b00, 1'b1);
    resolve(10'h005, 2'b00, 1'b0); set_hist(2'b00);
    look(10'h005, "R4 single miss keeps taken", 1);
    resolve(10'h005, 2'b00, 1'b0); set_hist(2'b00);
    look(10'h005, "R4 second miss flips", 0);
    resolve(10'h005, 2'b00, 1'b0); resolve(10'h005, 2'b00, 1'b0);
    resolve(10'h005, 2'b00, 1'b0);
    resolve(10'h005, 2'b00, 1'b1); set_hist(2'b00);
    look(10'h005, "R3 floor saturates", 0);
    resolve(10'h005, 2'b00, 1'b1); set_hist(2'b00);
    look(10'h005, "R3 leaves floor", 1);
  endtask

  task automatic t_history;
    resolve(10'h040, 2'b00, 1'b1); resolve(10'h040, 2'b00, 1'b0);
    #1 chk("R5 T then N gives 10", pred_hist, 2);
    resolve(10'h040, 2'b00, 1'b0); resolve(10'h040, 2'b00, 1'b1);
    #1 chk("R5 N then T gives 01", pred_hist, 1);
  endtask

  task automatic t_concat;
    resolve(10'h007, 2'b01, 1'b1); resolve(10'h007, 2'b01, 1'b1);
    set_hist(2'b01);
    look(10'h007, "R6 trained history", 1);
    set_hist(2'b00);
    look(10'h007, "R6 other history separate", 0);
    look(10'h006, "R8 neighbour untouched", 0);
  endtask

  task automatic t_stale;
    set_hist(2'b11);
    resolve(10'h020, 2'b10, 1'b1); resolve(10'h020, 2'b10, 1'b1);
    set_hist(2'b10);
    look(10'h020, "R9 supplied history entry", 1);
    set_hist(2'b11);
    look(10'h020, "R9 live history entry untouched", 0);
  endtask

  task automatic t_idle;
    logic [HB-1:0] h0;
    set_hist(2'b00);
    h0 = pred_hist;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      upd_pc = 10'h005; upd_hist = 2'b00; upd_taken = k[0];
    end
    @(negedge clk);
    chk("R10 idle history", pred_hist, h0);
    look(10'h005, "R10 idle counter", 1);
    look(10'h009, "R10 idle other", 0);
  endtask

  task automatic t_mixed;
    logic [15:0] lf = 16'hACE1;
    for (int k = 0; k < 120; k++) begin
      logic [PCB-1:0] pc;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pc = {5'b0, lf[4:0]};
      resolve(pc, (lf[7] ? mhist : lf[9:8]), lf[5] | lf[6]);
      pred_pc = {5'b0, lf[12:8]};
      #1;
      chk("R2 mixed lookup", pred_taken, mdl[{mhist, pred_pc}] >> 1);
      chk("R5 mixed history", pred_hist, mhist);
    end
  endtask

  task automatic x_resolve(input logic [XPC-1:0] pc, input logic [XHB-1:0] h, input logic t);
    @(negedge clk);
    x_upd_valid = 1'b1; x_upd_pc = pc; x_upd_hist = h; x_upd_taken = t;
    @(negedge clk);
    x_upd_valid = 1'b0;
  endtask

  task automatic t_xor;
    // train index 5^3 = 6; live history goes 000 -> 001 -> 011
    x_resolve(6'd5, 3'b011, 1'b1);
    x_resolve(6'd5, 3'b011, 1'b1);
    x_resolve(6'h20, 3'b000, 1'b0);   // history now 110
    #1 chk("R5 xor inst history", x_pred_hist, 6);
    x_pred_pc = 6'd0; #1;
    chk("R7 0 xor 110 hits index 6", x_pred_taken, 1);
    x_pred_pc = 6'd5; #1;
    chk("R7 5 xor 110 misses", x_pred_taken, 0);
  endtask

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<(PCB+HB)); i++) mdl[i] = 1;
    mhist = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hysteresis();
    t_history();
    t_concat();
    t_stale();
    t_idle();
    t_mixed();
    t_xor();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule